// File: doc/BRIEF.md
# Zoned secure backup register file

The block is a bank of 32-bit backup words behind a simple single-cycle register bus. Every request arrives with two attributes: whether the caller is secure and whether it is privileged. Two boundary values, held in a security configuration word, split the bank into three contiguous zones. The lowest zone is private to secure callers. The middle zone is writable only by secure callers but readable by anyone. The top zone is open to all callers.

A privilege configuration word can further restrict bank access, or bank writes only, to privileged callers. A third gate covers the control words themselves. A read-only capability word reports how many backup words are implemented. A build-time option selects a legacy polarity for the control-protection bit. A request that is refused returns zero, leaves all state untouched, and raises an error pulse.

Top module: `bkz_regfile`

## Requirements
- R1: After reset, every backup word, the security configuration word and the privilege configuration word read as zero, and `rdata` and `err` are low.
- R2: A backup word in zone 1 (index below the first boundary) can be read and written by secure callers. A non-secure read of it returns zero with `err` high. A non-secure write to it is dropped with `err` high.
- R3: A backup word in zone 2 can be read by any caller and written only by secure callers. A non-secure write is dropped with `err` high.
- R4: A backup word in zone 3 can be read and written by secure and non-secure callers alike.
- R5: With boundaries Z1 and Z2, index i is in zone 3 when i >= Z2, else in zone 1 when i < Z1, else in zone 2. Z1 = 0 empties zone 1. Z2 = 0 puts every word in zone 3, whatever Z1 holds.
- R6: A boundary value above the implemented word count behaves exactly like a value equal to that count.
- R7: The security configuration word is at byte offset 0x020. Z1 sits in bits 7:0, Z2 in bits 23:16, and the control-protection bit in bit 31. All other bits read as zero.
- R8: The privilege configuration word is at byte offset 0x024 and only bits 29, 30 and 31 are stored. When bit 29 is set, unprivileged callers can neither read nor write backup words. When bit 30 is set, unprivileged callers cannot write backup words.
- R9: A read of either configuration word is refused (zero, `err` high) when control protection is active and the caller is non-secure, or when privilege bit 31 is set and the caller is unprivileged.
- R10: With `LEGACY_POLARITY` = 0, control protection is active when security bit 31 is 1. With `LEGACY_POLARITY` = 1 the sense is inverted: protection is active when the bit is 0, which includes the state after reset.
- R11: The word at byte offset 0x3F0 reads as the implemented word count in bits 7:0 for any caller. A write to it is dropped with `err` high.
- R12: Only a caller that is both secure and privileged can change either configuration word. Any other write to them is dropped with `err` high.
- R13: Backup word n is at byte offset 0x100 + 4n. An access to any unmapped offset returns zero with `err` high. `rdata` and `err` belong to the request sampled at the previous rising edge. Both are zero in any cycle that follows an edge with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled at the rising edge |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte offset of the target word |
| wdata | input | 32 | Write data |
| sec | input | 1 | Caller is secure |
| priv | input | 1 | Caller is privileged |
| rdata | output | 32 | Read data of the previous request, zero if refused or a write |
| err | output | 1 | One-cycle pulse: previous request was refused |

## Verification
The read data and the error flag of a request are both due one cycle after the rising edge that samples it. A configuration write changes the zone map and the gates for the next request, and never for the request that performs the write. The bench drives each request on a falling edge and samples `rdata` and `err` on the following falling edge, one register stage later. It then leaves an idle cycle, which is used to confirm that the error pulse has cleared. Zone and gate changes are always checked on later requests. A second instance built with the legacy polarity checks the inverted protection bit from reset.

// File: rtl/bkz_pkg.sv
package bkz_pkg;
    typedef enum logic [1:0] {
        ZONE_SEC_ONLY = 2'd0,
        ZONE_NS_READ  = 2'd1,
        ZONE_OPEN     = 2'd2
    } zone_e;

    localparam int unsigned ADDR_W      = 10;
    localparam logic [9:0]  OFF_SECCFG  = 10'h020;
    localparam logic [9:0]  OFF_PRIVCFG = 10'h024;
    localparam logic [9:0]  OFF_HWCFG   = 10'h3F0;
    localparam logic [9:0]  OFF_BANK    = 10'h100;

    localparam logic [31:0] SECCFG_MASK  = 32'h80FF_00FF;
    localparam logic [31:0] PRIVCFG_MASK = 32'hE000_0000;

    localparam int unsigned SEC_PROT_BIT  = 31;
    localparam int unsigned PRIV_RW_BIT   = 29;
    localparam int unsigned PRIV_WR_BIT   = 30;
    localparam int unsigned PRIV_CTRL_BIT = 31;
endpackage

// File: rtl/bkz_zone_map.sv
module bkz_zone_map #(
    parameter int unsigned NUM_REGS = 32
) (
    input  logic [7:0]      idx,
    input  logic [7:0]      z1_end,
    input  logic [7:0]      z2_end,
    output bkz_pkg::zone_e  zone
);
    localparam logic [7:0] CNT = NUM_REGS[7:0];

    logic [7:0] z1_c;
    logic [7:0] z2_c;

    always_comb begin
        z1_c = (z1_end > CNT) ? CNT : z1_end;
        z2_c = (z2_end > CNT) ? CNT : z2_end;
        if (idx >= z2_c) begin
            zone = bkz_pkg::ZONE_OPEN;
        end else if (idx < z1_c) begin
            zone = bkz_pkg::ZONE_SEC_ONLY;
        end else begin
            zone = bkz_pkg::ZONE_NS_READ;
        end
    end
endmodule

// File: rtl/bkz_bank_policy.sv
module bkz_bank_policy (
    input  bkz_pkg::zone_e zone,
    input  logic           is_write,
    input  logic           sec,
    input  logic           priv,
    input  logic           priv_rw_only,
    input  logic           priv_wr_only,
    output logic           allow
);
    logic zone_ok;
    logic priv_ok;

    always_comb begin
        unique case (zone)
            bkz_pkg::ZONE_SEC_ONLY: zone_ok = sec;
            bkz_pkg::ZONE_NS_READ:  zone_ok = sec || !is_write;
            default:                zone_ok = 1'b1;
        endcase
        priv_ok = priv || (!priv_rw_only && !(priv_wr_only && is_write));
        allow   = zone_ok && priv_ok;
    end
endmodule

// File: rtl/bkz_regfile.sv
module bkz_regfile #(
    parameter int unsigned NUM_REGS        = 32,
    parameter bit          LEGACY_POLARITY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [9:0]  addr,
    input  logic [31:0] wdata,
    input  logic        sec,
    input  logic        priv,
    output logic [31:0] rdata,
    output logic        err
);
    import bkz_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam logic [7:0]  CNT   = NUM_REGS[7:0];

    typedef struct packed {
        logic [NUM_REGS-1:0][31:0] bank;
        logic [31:0]               seccfg;
        logic [31:0]               privcfg;
        logic [31:0]               rdata;
        logic                      err;
    } state_t;

    state_t st_d, st_q;

    logic [7:0]       idx_full;
    logic [IDX_W-1:0] bidx;
    logic             bank_hit;
    logic             bank_allow;
    logic             ctrl_sec_only;
    logic             ctrl_rd_ok;
    logic             cfg_wr_ok;
    zone_e            zone;

    assign idx_full = addr[9:2] - OFF_BANK[9:2];
    assign bidx     = idx_full[IDX_W-1:0];
    assign bank_hit = (addr >= OFF_BANK) && (addr[1:0] == 2'b00) && (idx_full < CNT);

    bkz_zone_map #(.NUM_REGS(NUM_REGS)) u_zone (
        .idx    (idx_full),
        .z1_end (st_q.seccfg[7:0]),
        .z2_end (st_q.seccfg[23:16]),
        .zone   (zone)
    );

    bkz_bank_policy u_policy (
        .zone         (zone),
        .is_write     (we),
        .sec          (sec),
        .priv         (priv),
        .priv_rw_only (st_q.privcfg[PRIV_RW_BIT]),
        .priv_wr_only (st_q.privcfg[PRIV_WR_BIT]),
        .allow        (bank_allow)
    );

    generate
        if (LEGACY_POLARITY) begin : g_inv_prot
            assign ctrl_sec_only = ~st_q.seccfg[SEC_PROT_BIT];
        end else begin : g_std_prot
            assign ctrl_sec_only = st_q.seccfg[SEC_PROT_BIT];
        end
    endgenerate

    assign ctrl_rd_ok = !(ctrl_sec_only && !sec) && !(st_q.privcfg[PRIV_CTRL_BIT] && !priv);
    assign cfg_wr_ok  = sec && priv;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = 1'b0;
        if (req) begin
            if (bank_hit) begin
                if (!bank_allow) begin
                    st_d.err = 1'b1;
                end else if (we) begin
                    st_d.bank[bidx] = wdata;
                end else begin
                    st_d.rdata = st_q.bank[bidx];
                end
            end else if (addr == OFF_SECCFG || addr == OFF_PRIVCFG) begin
                if (we) begin
                    if (!cfg_wr_ok) begin
                        st_d.err = 1'b1;
                    end else if (addr == OFF_SECCFG) begin
                        st_d.seccfg = wdata & SECCFG_MASK;
                    end else begin
                        st_d.privcfg = wdata & PRIVCFG_MASK;
                    end
                end else if (!ctrl_rd_ok) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.rdata = (addr == OFF_SECCFG) ? st_q.seccfg : st_q.privcfg;
                end
            end else if (addr == OFF_HWCFG && !we) begin
                st_d.rdata = {24'd0, CNT};
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

    // R2
    refused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == 32'd0));

    // R2
    refused_bank_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(st_q.bank));

    // R4
    open_zone_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && bank_hit && zone == ZONE_OPEN && !st_q.privcfg[PRIV_RW_BIT]) |=> !err);

    // R11
    hwcfg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr == OFF_HWCFG) |=> (rdata == {24'd0, CNT} && !err));

    // R12
    cfg_write_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !(sec && priv)) |=> ($stable(st_q.seccfg) && $stable(st_q.privcfg)));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!err && rdata == 32'd0));
endmodule

// File: tb/sim_bkz_regfile.sv
`timescale 1ns/1ps
module sim_bkz_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        sec = 1'b0;
    logic        priv = 1'b0;
    logic [31:0] rdata, rdata_l;
    logic        err, err_l;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] got_d;
    logic        got_e;
    logic [31:0] got_ld;
    logic        got_le;

    always #10 clk = ~clk;

    bkz_regfile #(.NUM_REGS(32), .LEGACY_POLARITY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .sec(sec), .priv(priv), .rdata(rdata), .err(err));

    bkz_regfile #(.NUM_REGS(32), .LEGACY_POLARITY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .sec(sec), .priv(priv), .rdata(rdata_l), .err(err_l));

    typedef struct packed {
        logic        w;
        logic        s;
        logic        p;
        logic [9:0]  a;
        logic [31:0] wd;
        logic [31:0] ed;
        logic        ee;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1,1'b1,1'b1,10'h020,32'h000A_0004,32'h0,1'b0,4'd12}, // R12 Z1=4 Z2=10
        '{1'b0,1'b1,1'b1,10'h020,32'h0,32'h000A_0004,1'b0,4'd7},  // R7
        '{1'b1,1'b1,1'b1,10'h108,32'h1111_2222,32'h0,1'b0,4'd2},  // R2
        '{1'b0,1'b1,1'b1,10'h108,32'h0,32'h1111_2222,1'b0,4'd2},
        '{1'b0,1'b0,1'b1,10'h108,32'h0,32'h0,1'b1,4'd2},
        '{1'b1,1'b0,1'b1,10'h108,32'hDEAD_BEEF,32'h0,1'b1,4'd2},
        '{1'b0,1'b1,1'b1,10'h108,32'h0,32'h1111_2222,1'b0,4'd2},
        '{1'b1,1'b1,1'b1,10'h114,32'h5555_AAAA,32'h0,1'b0,4'd3},  // R3
        '{1'b0,1'b0,1'b1,10'h114,32'h0,32'h5555_AAAA,1'b0,4'd3},
        '{1'b1,1'b0,1'b1,10'h114,32'h0BAD_0BAD,32'h0,1'b1,4'd3},
        '{1'b0,1'b1,1'b1,10'h114,32'h0,32'h5555_AAAA,1'b0,4'd3},
        '{1'b1,1'b0,1'b1,10'h150,32'hCAFE_F00D,32'h0,1'b0,4'd4},  // R4
        '{1'b0,1'b0,1'b1,10'h150,32'h0,32'hCAFE_F00D,1'b0,4'd4},
        '{1'b1,1'b1,1'b1,10'h150,32'h0C0F_FEE0,32'h0,1'b0,4'd4},
        '{1'b0,1'b0,1'b1,10'h150,32'h0,32'h0C0F_FEE0,1'b0,4'd4},
        '{1'b0,1'b0,1'b1,10'h10C,32'h0,32'h0,1'b1,4'd5},          // R5 idx3 zone1
        '{1'b0,1'b0,1'b1,10'h110,32'h0,32'h0,1'b0,4'd5},          // idx4 zone2
        '{1'b1,1'b0,1'b1,10'h124,32'h9999_9999,32'h0,1'b1,4'd5},  // idx9 zone2
        '{1'b1,1'b0,1'b1,10'h128,32'h0A0A_0A0A,32'h0,1'b0,4'd5},  // idx10 zone3
        '{1'b0,1'b0,1'b1,10'h128,32'h0,32'h0A0A_0A0A,1'b0,4'd5},
        '{1'b0,1'b0,1'b0,10'h3F0,32'h0,32'h0000_0020,1'b0,4'd11}, // R11
        '{1'b1,1'b1,1'b1,10'h3F0,32'h0000_00FF,32'h0,1'b1,4'd11},
        '{1'b0,1'b1,1'b1,10'h3F0,32'h0,32'h0000_0020,1'b0,4'd11},
        '{1'b0,1'b1,1'b1,10'h200,32'h0,32'h0,1'b1,4'd13},         // R13
        '{1'b0,1'b1,1'b1,10'h180,32'h0,32'h0,1'b1,4'd13},
        '{1'b1,1'b0,1'b1,10'h020,32'h0,32'h0,1'b1,4'd12},         // R12
        '{1'b1,1'b1,1'b0,10'h020,32'h0,32'h0,1'b1,4'd12},
        '{1'b0,1'b1,1'b1,10'h020,32'h0,32'h000A_0004,1'b0,4'd12},
        '{1'b1,1'b1,1'b1,10'h020,32'hFFFF_FFFF,32'h0,1'b0,4'd7},  // R7
        '{1'b0,1'b1,1'b1,10'h020,32'h0,32'h80FF_00FF,1'b0,4'd7},
        '{1'b0,1'b0,1'b1,10'h020,32'h0,32'h0,1'b1,4'd9},          // R9
        '{1'b0,1'b0,1'b1,10'h17C,32'h0,32'h0,1'b1,4'd6},          // R6
        '{1'b1,1'b1,1'b1,10'h020,32'h00FF_0000,32'h0,1'b0,4'd6},
        '{1'b0,1'b0,1'b1,10'h150,32'h0,32'h0C0F_FEE0,1'b0,4'd6},
        '{1'b1,1'b0,1'b1,10'h17C,32'h1234_5678,32'h0,1'b1,4'd6},
        '{1'b0,1'b1,1'b1,10'h17C,32'h0,32'h0,1'b0,4'd6},
        '{1'b1,1'b1,1'b1,10'h020,32'h0000_0008,32'h0,1'b0,4'd5},  // R5 Z2=0
        '{1'b1,1'b0,1'b1,10'h108,32'h0000_0022,32'h0,1'b0,4'd5},
        '{1'b0,1'b0,1'b1,10'h108,32'h0,32'h0000_0022,1'b0,4'd5},
        '{1'b1,1'b1,1'b1,10'h024,32'h4000_0000,32'h0,1'b0,4'd8},  // R8
        '{1'b0,1'b1,1'b1,10'h024,32'h0,32'h4000_0000,1'b0,4'd8},
        '{1'b0,1'b1,1'b0,10'h150,32'h0,32'h0C0F_FEE0,1'b0,4'd8},
        '{1'b1,1'b1,1'b0,10'h150,32'h0000_0001,32'h0,1'b1,4'd8},
        '{1'b1,1'b0,1'b1,10'h150,32'h0000_0001,32'h0,1'b0,4'd8},
        '{1'b1,1'b1,1'b1,10'h024,32'h2000_0000,32'h0,1'b0,4'd8},
        '{1'b0,1'b1,1'b0,10'h150,32'h0,32'h0,1'b1,4'd8},
        '{1'b0,1'b0,1'b1,10'h150,32'h0,32'h0000_0001,1'b0,4'd8},
        '{1'b1,1'b1,1'b1,10'h024,32'h8000_0000,32'h0,1'b0,4'd9},  // R9
        '{1'b0,1'b1,1'b0,10'h024,32'h0,32'h0,1'b1,4'd9},
        '{1'b0,1'b0,1'b1,10'h024,32'h0,32'h8000_0000,1'b0,4'd9},
        '{1'b1,1'b1,1'b1,10'h024,32'hFFFF_FFFF,32'h0,1'b0,4'd8},  // R8
        '{1'b0,1'b1,1'b1,10'h024,32'h0,32'hE000_0000,1'b0,4'd8},
        '{1'b0,1'b1,1'b1,10'h028,32'h0,32'h0,1'b1,4'd13}          // R13
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic s, input logic p,
                          input logic [9:0] a, input logic [31:0] wd);
        @(negedge clk);
        req = 1'b1; we = w; sec = s; priv = p; addr = a; wdata = wd;
        @(negedge clk);
        got_d = rdata; got_e = err; got_ld = rdata_l; got_le = err_l;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        check("R1 rdata after reset", rdata, 32'h0);
        check("R1 err after reset", {31'd0, err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].w, VECS[i].s, VECS[i].p, VECS[i].a, VECS[i].wd);
            check($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), got_d, VECS[i].ed);
            check($sformatf("R%0d vec%0d err", VECS[i].rq, i), {31'd0, got_e}, {31'd0, VECS[i].ee});
        end

        // R13: error pulse clears after an idle cycle
        @(negedge clk);
        check("R13 err after idle", {31'd0, err}, 32'h0);

        // R1: state returns to zero after a second reset
        do_reset();
        @(negedge clk);
        check("R1 err after re-reset", {31'd0, err}, 32'h0);
        access(1'b0, 1'b1, 1'b1, 10'h150, 32'h0);
        check("R1 bank word cleared", got_d, 32'h0);
        access(1'b0, 1'b1, 1'b1, 10'h020, 32'h0);
        check("R1 seccfg cleared", got_d, 32'h0);
        access(1'b0, 1'b1, 1'b1, 10'h024, 32'h0);
        check("R1 privcfg cleared", got_d, 32'h0);

        // R10: standard polarity allows non-secure control read after reset
        access(1'b0, 1'b0, 1'b1, 10'h020, 32'h0);
        check("R10 std ns read err", {31'd0, got_e}, 32'h0);
        // R10: legacy polarity blocks it after reset
        check("R10 legacy ns read err", {31'd0, got_le}, 32'h1);
        check("R10 legacy ns read data", got_ld, 32'h0);
        access(1'b1, 1'b1, 1'b1, 10'h020, 32'h8000_0000);
        access(1'b0, 1'b0, 1'b1, 10'h020, 32'h0);
        check("R10 legacy bit set ns err", {31'd0, got_le}, 32'h0);
        check("R10 legacy bit set ns data", got_ld, 32'h8000_0000);
        check("R10 std bit set ns err", {31'd0, got_e}, 32'h1);
        access(1'b1, 1'b1, 1'b1, 10'h020, 32'h0);
        access(1'b0, 1'b0, 1'b1, 10'h020, 32'h0);
        check("R10 legacy bit clear ns err", {31'd0, got_le}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule